// File: doc/BRIEF.md
# Sixteen-to-36-bit DMA write packer

This block sits between a peripheral bus that performs 16-bit word writes at byte addresses and a memory built from 36-bit words. Each memory word is viewed as two 18-bit halves, and each half carries exactly one 16-bit bus word in its low 16 bits. The two spare bits at the top of a half are always written as zero, so a peripheral that writes only 16 bits can never leave stale high bits behind.

Bus byte addresses pass through a table of page-map entries. Each entry covers 512 bytes and holds a valid flag and a memory page base. A write to an even bus word writes the whole memory word at once and keeps a copy of the even data. A following odd write to the same word then writes the whole word again from that copy, so no read is needed. An odd write with no matching copy falls back to a read-merge-write through a small read port. A sequential flag lets a requester stream a burst without supplying addresses. A write through an unmapped page is dropped and sets a sticky error flag.

Top module: `dma_word_packer`

## Requirements
- R1: An accepted write with bus address bit 1 clear produces, one clock later, a single-cycle memory write of {2'b00, data, 18'b0}: the left half holds the data in bits 33:18, and bits 35:34 and the whole right half are zero.
- R2: An accepted write with address bit 1 set, directly following an even write to the same memory word, produces one clock later a write of {2'b00, saved even data, 2'b00, new data} and no memory read. The saved copy is then used up.
- R3: An odd write with no usable saved even word asserts the read enable at the target word address for one cycle, starting one clock after acceptance. Two clocks after that the block writes {2'b00, bits 33:18 of the read word, 2'b00, new data}.
- R4: The memory word address is the 9-bit page base of the map entry indexed by bus address bits 17:9, followed by bus address bits 8:2.
- R5: A write through a map entry whose valid bit is clear writes nothing and sets the error output. The error output stays set until reset, and later valid writes complete normally.
- R6: With the sequential flag set, the bus address is ignored and the write uses the previously accepted byte address plus 2. This also holds across a page boundary. Bus byte addresses are always even.
- R7: The saved even word lasts only until the next accepted write. Two even writes followed by an odd write to the first word take the read-merge path.
- R8: Bus bytes are little-endian within a bus word: bytes 0x05 then 0x06 (data 0x0605) give the halfword octal 003005.
- R9: After reset, ready is 1, the error flag is 0, both memory enables are 0 and every map entry is invalid.
- R10: A map entry written through the configuration port applies from the next accepted bus write.
- R11: Ready is low for the two cycles of a read-merge. Write strobes seen while ready is low cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus word write strobe, taken when bus_ready is 1 |
| bus_seq | input | 1 | Use previous byte address plus 2 instead of bus_addr |
| bus_addr | input | 18 | Bus byte address (even) |
| bus_data | input | 16 | Bus write data, lower-addressed byte in bits 7:0 |
| bus_ready | output | 1 | Block can accept a write this cycle |
| nxm_err | output | 1 | Sticky unmapped-page error |
| map_wr | input | 1 | Page-map entry write strobe |
| map_idx | input | 9 | Page-map entry index |
| map_vld | input | 1 | Valid flag for the entry being written |
| map_base | input | 9 | Memory page base for the entry being written |
| mem_wr_en | output | 1 | Memory word write enable |
| mem_wr_addr | output | 16 | Memory word write address |
| mem_wr_data | output | 36 | Memory word write data |
| mem_rd_en | output | 1 | Memory word read enable (merge only) |
| mem_rd_addr | output | 16 | Memory word read address |
| mem_rd_data | input | 36 | Read data, valid one clock after mem_rd_en |

## Verification
The bench checks that the spare bits are cleared even when the data is all ones. A design that kept the old memory bits would show a nonzero top digit there. It checks bursts that step through a page's last word into the next page. A design that stepped by one byte, or ignored the page change, would write to the wrong word address. It also checks that the saved even copy is invalidated by an intervening even write and consumed by its own odd partner. A stale copy would produce a pair write where a read-merge is required. Finally, it checks that unmapped writes leave memory untouched, that strobes during a merge are ignored, and that the merge keeps only bits 33:18 of the word it reads.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;
    parameter int BUS_AW   = 18;
    parameter int BUS_DW   = 16;
    parameter int HALF_W   = 18;
    parameter int WORD_W   = 2 * HALF_W;
    parameter int PAGE_OFS = 9;
    parameter int WADR_W   = BUS_AW - 1;
    parameter int PAGE_W   = BUS_AW - PAGE_OFS;
    parameter int MAP_N    = 1 << PAGE_W;
    parameter int OFS_W    = PAGE_OFS - 2;
    parameter int BASE_W   = 9;
    parameter int MEM_AW   = BASE_W + OFS_W;

    typedef struct packed {
        logic              vld;
        logic [BASE_W-1:0] base;
    } map_ent_t;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_RD   = 2'd1,
        PK_MRG  = 2'd2
    } pk_state_t;

    function automatic logic [HALF_W-1:0] zfill_half(input logic [BUS_DW-1:0] d);
        return {{(HALF_W-BUS_DW){1'b0}}, d};
    endfunction

    function automatic logic [WORD_W-1:0] left_keep_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        m[HALF_W +: BUS_DW] = '1;
        return m;
    endfunction
endpackage

// File: rtl/dma_pagemap.sv
module dma_pagemap
    import dma_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [PAGE_W-1:0] cfg_idx,
    input  map_ent_t          cfg_ent,
    input  logic [PAGE_W-1:0] lk_page,
    output map_ent_t          lk_ent
);
    map_ent_t tbl [MAP_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAP_N; i++) begin
                tbl[i] <= '0;
            end
        end else if (cfg_we) begin
            tbl[cfg_idx] <= cfg_ent;
        end
    end

    assign lk_ent = tbl[lk_page];

    // R10: a configuration write is visible in the table one clock later
    p_map_update_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> tbl[$past(cfg_idx)] == $past(cfg_ent));
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              seq,
    input  logic [WADR_W-1:0] in_wadr,
    output logic [WADR_W-1:0] cur_wadr
);
    logic [WADR_W-1:0] last_wadr;

    // word-granular address: one bus word is two bytes, so +1 here is +2 on the bus
    assign cur_wadr = seq ? (last_wadr + WADR_W'(1)) : in_wadr;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_wadr <= '0;
        end else if (acc) begin
            last_wadr <= cur_wadr;
        end
    end

    // R6: a sequential write advances exactly one bus word
    p_burst_step_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && seq) |=> last_wadr == $past(last_wadr) + WADR_W'(1));
endmodule

// File: rtl/dma_pack_core.sv
module dma_pack_core
    import dma_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_data,
    input  logic              odd_sel,
    input  logic [OFS_W-1:0]  word_ofs,
    input  map_ent_t          ent,
    output logic              acc,
    output logic              bus_ready,
    output logic              nxm_err,
    output logic              mem_wr_en,
    output logic [MEM_AW-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data
);
    pk_state_t         state;
    logic              sav_vld;
    logic [MEM_AW-1:0] sav_addr;
    logic [BUS_DW-1:0] sav_dat;
    logic [BUS_DW-1:0] pend_dat;
    logic [MEM_AW-1:0] tgt_addr;
    logic              pair_hit;
    logic [WORD_W-1:0] merged;

    assign bus_ready = (state == PK_IDLE);
    assign acc       = bus_wr && bus_ready;
    assign tgt_addr  = {ent.base, word_ofs};
    assign pair_hit  = sav_vld && (sav_addr == tgt_addr);
    assign mem_rd_en = (state == PK_RD);
    assign merged    = (mem_rd_data & left_keep_mask()) | {{HALF_W{1'b0}}, zfill_half(pend_dat)};

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PK_IDLE;
            sav_vld     <= 1'b0;
            sav_addr    <= '0;
            sav_dat     <= '0;
            pend_dat    <= '0;
            nxm_err     <= 1'b0;
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
            mem_rd_addr <= '0;
        end else begin
            mem_wr_en <= 1'b0;
            case (state)
                PK_IDLE: begin
                    if (acc) begin
                        sav_vld <= 1'b0;
                        if (!ent.vld) begin
                            nxm_err <= 1'b1;
                        end else if (!odd_sel) begin
                            mem_wr_en   <= 1'b1;
                            mem_wr_addr <= tgt_addr;
                            mem_wr_data <= {zfill_half(bus_data), {HALF_W{1'b0}}};
                            sav_vld     <= 1'b1;
                            sav_addr    <= tgt_addr;
                            sav_dat     <= bus_data;
                        end else if (pair_hit) begin
                            mem_wr_en   <= 1'b1;
                            mem_wr_addr <= tgt_addr;
                            mem_wr_data <= {zfill_half(sav_dat), zfill_half(bus_data)};
                        end else begin
                            state       <= PK_RD;
                            mem_rd_addr <= tgt_addr;
                            pend_dat    <= bus_data;
                        end
                    end
                end
                PK_RD: begin
                    state <= PK_MRG;
                end
                PK_MRG: begin
                    mem_wr_en   <= 1'b1;
                    mem_wr_addr <= mem_rd_addr;
                    mem_wr_data <= merged;
                    state       <= PK_IDLE;
                end
                default: state <= PK_IDLE;
            endcase
        end
    end

    // R1: spare bits of both halves are never written as one
    p_spare_zero_r1: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wr_data[WORD_W-1 -: 2] == 2'b00) && (mem_wr_data[HALF_W-1 -: 2] == 2'b00));
    // R3: a merge read is followed two clocks later by the write
    p_merge_seq_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> ##1 (mem_wr_en && mem_wr_addr == $past(mem_rd_addr, 2)));
    // R11: the bus is held off while a read is outstanding
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !bus_ready);
    // R5: the error flag is sticky
    p_nxm_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        nxm_err |=> nxm_err);
    // R2: a paired odd write never needs a read
    p_pair_no_read_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && ent.vld && odd_sel && pair_hit) |=> (mem_wr_en && !mem_rd_en));
endmodule

// File: rtl/dma_word_packer.sv
module dma_word_packer
    import dma_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_seq,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_data,
    output logic              bus_ready,
    output logic              nxm_err,
    input  logic              map_wr,
    input  logic [PAGE_W-1:0] map_idx,
    input  logic              map_vld,
    input  logic [BASE_W-1:0] map_base,
    output logic              mem_wr_en,
    output logic [MEM_AW-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data
);
    logic              acc;
    logic [WADR_W-1:0] cur_wadr;
    map_ent_t          cfg_ent;
    map_ent_t          lk_ent;

    assign cfg_ent = '{vld: map_vld, base: map_base};

    dma_addr_step u_step (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .seq      (bus_seq),
        .in_wadr  (bus_addr[BUS_AW-1:1]),
        .cur_wadr (cur_wadr)
    );

    dma_pagemap u_map (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (map_wr),
        .cfg_idx (map_idx),
        .cfg_ent (cfg_ent),
        .lk_page (cur_wadr[WADR_W-1 -: PAGE_W]),
        .lk_ent  (lk_ent)
    );

    dma_pack_core u_core (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_data    (bus_data),
        .odd_sel     (cur_wadr[0]),
        .word_ofs    (cur_wadr[OFS_W:1]),
        .ent         (lk_ent),
        .acc         (acc),
        .bus_ready   (bus_ready),
        .nxm_err     (nxm_err),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    // R6: the bus only issues word-aligned byte addresses
    p_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_seq) |-> !bus_addr[0]);
endmodule

// File: tb/dma_word_packer_tb.sv
`timescale 1ns/1ps
module dma_word_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_seq;
    logic [17:0] bus_addr;
    logic [15:0] bus_data;
    logic        bus_ready, nxm_err;
    logic        map_wr, map_vld;
    logic [8:0]  map_idx, map_base;
    logic        mem_wr_en, mem_rd_en;
    logic [15:0] mem_wr_addr, mem_rd_addr;
    logic [35:0] mem_wr_data, mem_rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_word_packer dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_seq(bus_seq),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_ready(bus_ready),
        .nxm_err(nxm_err), .map_wr(map_wr), .map_idx(map_idx),
        .map_vld(map_vld), .map_base(map_base), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data)
    );

    function automatic logic [35:0] pat(input logic [15:0] a);
        return {4'hF, a, a};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);
    end

    function automatic logic [15:0] wadr(input logic [8:0] base, input logic [17:0] a);
        return {base, a[8:2]};
    endfunction
    function automatic logic [35:0] lh(input logic [15:0] d);
        return {2'b00, d, 18'h0};
    endfunction
    function automatic logic [35:0] pr(input logic [15:0] a, input logic [15:0] b);
        return {2'b00, a, 2'b00, b};
    endfunction
    function automatic logic [35:0] mrg(input logic [15:0] wa, input logic [15:0] d);
        logic [35:0] p;
        p = pat(wa);
        return {2'b00, p[33:18], 2'b00, d};
    endfunction
    // vector: seq, addr, data, exp word addr, exp data
    function automatic logic [86:0] mkv(input logic s, input logic [17:0] a,
        input logic [15:0] d, input logic [15:0] ea, input logic [35:0] ed);
        return {s, a, d, ea, ed};
    endfunction

    localparam int NV = 10;
    localparam logic [86:0] VEC [NV] = '{
        mkv(1'b0, 18'h00A00, 16'h0605, wadr(9'h12, 18'h00A00), lh(16'h0605)),
        mkv(1'b0, 18'h00A02, 16'h1234, wadr(9'h12, 18'h00A02), pr(16'h0605, 16'h1234)),
        mkv(1'b0, 18'h00A04, 16'hFFFF, wadr(9'h12, 18'h00A04), lh(16'hFFFF)),
        mkv(1'b1, 18'h3FFFE, 16'hABCD, wadr(9'h12, 18'h00A06), pr(16'hFFFF, 16'hABCD)),
        mkv(1'b1, 18'h00000, 16'h1111, wadr(9'h12, 18'h00A08), lh(16'h1111)),
        mkv(1'b1, 18'h00000, 16'h2222, wadr(9'h12, 18'h00A0A), pr(16'h1111, 16'h2222)),
        mkv(1'b0, 18'h00BFC, 16'h3333, wadr(9'h12, 18'h00BFC), lh(16'h3333)),
        mkv(1'b1, 18'h00000, 16'h4444, wadr(9'h12, 18'h00BFE), pr(16'h3333, 16'h4444)),
        mkv(1'b1, 18'h00000, 16'h5555, wadr(9'h13, 18'h00C00), lh(16'h5555)),
        mkv(1'b1, 18'h00000, 16'h6666, wadr(9'h13, 18'h00C02), pr(16'h5555, 16'h6666))
    };

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic s, input logic [17:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_seq = s; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_seq = 1'b0;
    endtask

    task automatic map_set(input logic [8:0] idx, input logic v, input logic [8:0] b);
        map_wr = 1'b1; map_idx = idx; map_vld = v; map_base = b;
        @(negedge clk);
        map_wr = 1'b0;
    endtask

    task automatic chk_wr(input string req, input logic [15:0] ea, input logic [35:0] ed);
        chk(req, {35'h0, mem_wr_en}, 36'h1);
        chk(req, {20'h0, mem_wr_addr}, {20'h0, ea});
        chk(req, mem_wr_data, ed);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual hung expected done");
        summary();
    end

    initial begin
        rst = 1'b1; bus_wr = 0; bus_seq = 0; bus_addr = '0; bus_data = '0;
        map_wr = 0; map_idx = '0; map_vld = 0; map_base = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 ready", {35'h0, bus_ready}, 36'h1);
        chk("R9 nxm", {35'h0, nxm_err}, 36'h0);
        chk("R9 wr_en", {35'h0, mem_wr_en}, 36'h0);
        chk("R9 rd_en", {35'h0, mem_rd_en}, 36'h0);

        map_set(9'd5, 1'b1, 9'h12);
        map_set(9'd6, 1'b1, 9'h13);

        // R1 R2 R4 R6 R8 table walk
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][86], VEC[i][85:68], VEC[i][67:52]);
            chk_wr($sformatf("R1/R2/R4/R6 vec%0d", i), VEC[i][51:36], VEC[i][35:0]);
            chk($sformatf("R2 no read vec%0d", i), {35'h0, mem_rd_en}, 36'h0);
            if (i == 0) chk("R8 halfword", {18'h0, mem_wr_data[35:18]}, {18'h0, 18'o003005});
        end

        // R3 + R11: unpaired odd write, stray strobe during merge
        do_write(1'b0, 18'h00A12, 16'h7777);
        bus_wr = 1'b1; bus_addr = 18'h00A40; bus_data = 16'h9999;
        chk("R3 rd_en", {35'h0, mem_rd_en}, 36'h1);
        chk("R3 rd_addr", {20'h0, mem_rd_addr}, {20'h0, wadr(9'h12, 18'h00A12)});
        chk("R11 ready low", {35'h0, bus_ready}, 36'h0);
        chk("R3 no early write", {35'h0, mem_wr_en}, 36'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R11 ready low 2", {35'h0, bus_ready}, 36'h0);
        chk("R3 rd_en one cycle", {35'h0, mem_rd_en}, 36'h0);
        @(negedge clk);
        chk_wr("R3 merge", wadr(9'h12, 18'h00A12), mrg(wadr(9'h12, 18'h00A12), 16'h7777));
        chk("R11 ready back", {35'h0, bus_ready}, 36'h1);
        @(negedge clk);
        chk("R11 stray ignored", {35'h0, mem_wr_en}, 36'h0);

        // R7: intervening even write invalidates saved copy
        do_write(1'b0, 18'h00A20, 16'h0101);
        do_write(1'b0, 18'h00A24, 16'h0202);
        do_write(1'b0, 18'h00A22, 16'h0303);
        chk("R7 merge read", {35'h0, mem_rd_en}, 36'h1);
        repeat (2) @(negedge clk);
        chk_wr("R7 merge", wadr(9'h12, 18'h00A20), mrg(wadr(9'h12, 18'h00A20), 16'h0303));

        // R2/R7: saved copy consumed by its pair
        do_write(1'b0, 18'h00A30, 16'h0A0A);
        do_write(1'b0, 18'h00A32, 16'h0B0B);
        chk_wr("R2 pair", wadr(9'h12, 18'h00A30), pr(16'h0A0A, 16'h0B0B));
        do_write(1'b0, 18'h00A32, 16'h0C0C);
        chk("R7 consumed", {35'h0, mem_rd_en}, 36'h1);
        repeat (2) @(negedge clk);
        chk_wr("R7 reodd", wadr(9'h12, 18'h00A30), mrg(wadr(9'h12, 18'h00A30), 16'h0C0C));

        // R5: unmapped page
        do_write(1'b0, 18'h00E00, 16'hDEAD);
        chk("R5 no write", {35'h0, mem_wr_en}, 36'h0);
        chk("R5 nxm set", {35'h0, nxm_err}, 36'h1);
        do_write(1'b0, 18'h00A00, 16'h0042);
        chk_wr("R5 later ok", wadr(9'h12, 18'h00A00), lh(16'h0042));
        chk("R5 sticky", {35'h0, nxm_err}, 36'h1);

        // R10: map entry update applies to next write
        map_set(9'd7, 1'b1, 9'h1F);
        do_write(1'b0, 18'h00E04, 16'h5A5A);
        chk_wr("R10 new map", wadr(9'h1F, 18'h00E04), lh(16'h5A5A));

        // R9: reset clears error and map
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 nxm cleared", {35'h0, nxm_err}, 36'h0);
        do_write(1'b0, 18'h00A00, 16'h1357);
        chk("R9 map invalid", {35'h0, mem_wr_en}, 36'h0);

        summary();
    end
endmodule